// File: doc/BRIEF.md
# Power-Management Event and Sleep Controller

This block gathers power-management events into a status register, qualifies them with an enable register and drives a level-sensitive system control interrupt (SCI). A tick counter runs whenever a clock-enable strobe is high. Its low 24 bits can be read back. The counter raises a timer event each time it crosses a power-of-two boundary. That boundary is rearmed whenever software clears the timer event.

Software reaches the block through a simple write/read port with a byte address. The status register clears a bit when a 1 is written to it. The enable register is plain read/write. Writing the control register with its sleep-enable bit set starts a sleep transition: either a soft power-off or a suspend that is recorded as a wake by the power button. An advanced power-management command port toggles the SCI-enable control bit. It can also raise a system-management interrupt pulse. A hot-plug event pair from a neighbouring general-purpose-event block also feeds the SCI.

Top module: `pm_event_ctrl`

## Requirements
- R1: After reset, status, enable, control and the tick count read 0, and sci, shutdown_req, reset_req, s3_active and smi are low.
- R2: sci is high while any of status bits 0 (timer), 5 (lock), 8 (button) or 10 (alarm) is set with the same enable bit, or while gpe_hp_sts and gpe_hp_en are both high.
- R3: Status bit 0 becomes 1 one cycle after the tick count first equals or exceeds the armed boundary. The boundary is 2^TMR_SHIFT out of reset.
- R4: Writing 1 to status bit 0 while it is set clears it. The same write rearms the boundary at the next multiple of 2^TMR_SHIFT above the current count. Writing 1 to any status bit clears it, and writing 1 to a clear bit changes nothing.
- R5: A control write (offset 0x4) stores the written value with bit 13 forced to 0. Enable (offset 0x2) stores its value as written. Offsets other than 0x0, 0x2, 0x4 and 0x8 read 0.
- R6: A control write with bit 13 = 1 and bits 12:10 = 0 makes shutdown_req high for exactly the next cycle.
- R7: A control write with bit 13 = 1 and bits 12:10 = 1 sets status bits 15 and 8, makes reset_req high for the next cycle, and sets s3_active, which stays high until reset. Other sleep types cause no pulse.
- R8: An APM command 0xF1 sets control bit 0 and 0xF0 clears it. Any other byte leaves the control register unchanged.
- R9: smi pulses high for one cycle after an APM command only when smi_cfg_en is high.
- R10: A pwrbtn_evt sets status bit 8 when enable bit 8 is set. Otherwise it makes shutdown_req high for the next cycle.
- R11: When a control write and an APM command fall in the same cycle, control bit 0 follows the APM command.
- R12: Offset 0x8 reads the low 24 bits of the tick count, which advances by one on each cycle with tick_en high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Tick counter advance strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of register |
| wr_data | input | 16 | Write data |
| rd_data | output | 24 | Read data for reg_addr (combinational) |
| pwrbtn_evt | input | 1 | Power-button event pulse |
| rtc_evt | input | 1 | Alarm event pulse (status bit 10) |
| glock_evt | input | 1 | Global-lock event pulse (status bit 5) |
| gpe_hp_sts | input | 1 | Hot-plug status from the GPE block |
| gpe_hp_en | input | 1 | Hot-plug enable from the GPE block |
| apm_wr | input | 1 | APM command strobe |
| apm_cmd | input | 8 | APM command byte |
| smi_cfg_en | input | 1 | Allows SMI pulses on APM commands |
| sci | output | 1 | Level system control interrupt |
| shutdown_req | output | 1 | Soft power-off request pulse |
| reset_req | output | 1 | System reset request pulse |
| s3_active | output | 1 | Suspend-to-RAM indication, sticky |
| smi | output | 1 | System-management interrupt pulse |

## Verification
A control-register write and an APM command can fall in the same cycle, and both modify control bit 0. The bench drives both in one cycle, once with the write clearing bit 0 and APM 0xF1 setting it, and once the other way round. It then reads the control register and expects the APM value. The bench also clears the timer status just as the count sits on a boundary, and checks that the status rearms only at the next boundary.

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl #(
  parameter int TICK_W    = 32,
  parameter int TMR_SHIFT = 23,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       wr_data,
  output logic [23:0]       rd_data,
  input  logic              pwrbtn_evt,
  input  logic              rtc_evt,
  input  logic              glock_evt,
  input  logic              gpe_hp_sts,
  input  logic              gpe_hp_en,
  input  logic              apm_wr,
  input  logic [7:0]        apm_cmd,
  input  logic              smi_cfg_en,
  output logic              sci,
  output logic              shutdown_req,
  output logic              reset_req,
  output logic              s3_active,
  output logic              smi
);
  localparam int B_TMR = 0, B_LCK = 5, B_BTN = 8, B_ALM = 10, B_WAK = 15;
  localparam int C_SCI = 0, C_SLP = 13;
  localparam logic [15:0] STS_KEEP = 16'h8521;
  localparam logic [15:0] SCI_SRC  = 16'h0521;
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(0), A_EN = ADDR_W'(2),
                                A_CTL = ADDR_W'(4), A_TMR = ADDR_W'(8);
  localparam logic [TICK_W-1:0] STEP = TICK_W'(1) << TMR_SHIFT;
  localparam logic [TICK_W-1:0] LOW  = STEP - TICK_W'(1);

  logic [15:0] sts_q, en_q, ctl_q, sts_d, ctl_d;
  logic [TICK_W-1:0] cnt_q, ovf_q;
  logic wr_sts, wr_en, wr_ctl, tmr_clr, slp_off, slp_s3;

  assign wr_sts  = reg_wr && reg_addr == A_STS;
  assign wr_en   = reg_wr && reg_addr == A_EN;
  assign wr_ctl  = reg_wr && reg_addr == A_CTL;
  assign tmr_clr = wr_sts && wr_data[B_TMR] && sts_q[B_TMR];
  assign slp_off = wr_ctl && wr_data[C_SLP] && wr_data[12:10] == 3'd0;
  assign slp_s3  = wr_ctl && wr_data[C_SLP] && wr_data[12:10] == 3'd1;

  always_comb begin
    sts_d = sts_q;
    if (wr_sts) sts_d = sts_d & ~wr_data;
    if (!tmr_clr && cnt_q >= ovf_q) sts_d[B_TMR] = 1'b1;
    if (glock_evt) sts_d[B_LCK] = 1'b1;
    if (rtc_evt) sts_d[B_ALM] = 1'b1;
    if (pwrbtn_evt && en_q[B_BTN]) sts_d[B_BTN] = 1'b1;
    if (slp_s3) begin
      sts_d[B_WAK] = 1'b1;
      sts_d[B_BTN] = 1'b1;
    end
    sts_d = sts_d & STS_KEEP;
  end

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl) begin
      ctl_d = wr_data;
      ctl_d[C_SLP] = 1'b0;
    end
    if (apm_wr && apm_cmd == 8'hF1) ctl_d[C_SCI] = 1'b1;
    if (apm_wr && apm_cmd == 8'hF0) ctl_d[C_SCI] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0; en_q <= '0; ctl_q <= '0;
      cnt_q <= '0; ovf_q <= STEP;
      shutdown_req <= 1'b0; reset_req <= 1'b0; s3_active <= 1'b0; smi <= 1'b0;
    end else begin
      sts_q <= sts_d;
      ctl_q <= ctl_d;
      if (wr_en) en_q <= wr_data;
      if (tick_en) cnt_q <= cnt_q + TICK_W'(1);
      if (tmr_clr) ovf_q <= (cnt_q + STEP) & ~LOW;
      shutdown_req <= slp_off || (pwrbtn_evt && !en_q[B_BTN]);
      reset_req    <= slp_s3;
      s3_active    <= s3_active || slp_s3;
      smi          <= apm_wr && smi_cfg_en;
    end
  end

  assign sci = (|(sts_q & en_q & SCI_SRC)) || (gpe_hp_sts && gpe_hp_en);

  always_comb begin
    case (reg_addr)
      A_STS:   rd_data = {8'h00, sts_q};
      A_EN:    rd_data = {8'h00, en_q};
      A_CTL:   rd_data = {8'h00, ctl_q};
      A_TMR:   rd_data = cnt_q[23:0];
      default: rd_data = '0;
    endcase
  end

  assert_tmr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr |=> !sts_q[B_TMR]);
  assert_ctl_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !apm_wr) |=> ctl_q == ($past(wr_data) & 16'hDFFF));
  assert_shutdown_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(slp_off || (pwrbtn_evt && !en_q[B_BTN])));
  assert_s3_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s3_active |=> s3_active);
  assert_smi_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    smi |-> $past(apm_wr && smi_cfg_en));
  assert_tick_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> cnt_q == $past(cnt_q) + TICK_W'(1));
endmodule

// File: tb/tb_pm_event_ctrl.sv
module tb_pm_event_ctrl;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic [23:0] rd_data;
  logic pwrbtn_evt = 0, rtc_evt = 0, glock_evt = 0, gpe_hp_sts = 0, gpe_hp_en = 0;
  logic apm_wr = 0, smi_cfg_en = 0;
  logic [7:0] apm_cmd = '0;
  logic sci, shutdown_req, reset_req, s3_active, smi;
  int checks = 0, errors = 0;

  pm_event_ctrl #(.TICK_W(32), .TMR_SHIFT(4), .ADDR_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
    .pwrbtn_evt(pwrbtn_evt), .rtc_evt(rtc_evt), .glock_evt(glock_evt),
    .gpe_hp_sts(gpe_hp_sts), .gpe_hp_en(gpe_hp_en), .apm_wr(apm_wr),
    .apm_cmd(apm_cmd), .smi_cfg_en(smi_cfg_en), .sci(sci),
    .shutdown_req(shutdown_req), .reset_req(reset_req),
    .s3_active(s3_active), .smi(smi));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {address, write data, expected readback}
  localparam logic [35:0] VEC [6] = '{
    {4'h2, 16'hA5A5, 16'hA5A5},
    {4'h2, 16'h0000, 16'h0000},
    {4'h4, 16'h1C02, 16'h1C02},
    {4'h4, 16'h2801, 16'h0801},
    {4'h0, 16'hFFFF, 16'h0000},
    {4'h6, 16'hFFFF, 16'h0000}
  };

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [23:0] d);
    reg_addr = a; #1; d = rd_data;
  endtask

  task automatic apm(logic [7:0] c);
    apm_wr = 1'b1; apm_cmd = c;
    @(negedge clk);
    apm_wr = 1'b0;
  endtask

  task automatic tick(int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'h0, v); check("R1 status", v, 0);
    rd(4'h2, v); check("R1 enable", v, 0);
    rd(4'h4, v); check("R1 control", v, 0);
    rd(4'h8, v); check("R1 timer", v, 0);
    check("R1 outputs", {19'd0, sci, shutdown_req, reset_req, s3_active, smi}, 0);

    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][35:32], VEC[i][31:16]);
      rd(VEC[i][35:32], v);
      check("R5 readback", v, {8'h00, VEC[i][15:0]});
      check("R5 no sleep pulse", {22'd0, shutdown_req, reset_req}, 0);
    end
    wr(4'h4, 16'h0000);

    tick(15);
    rd(4'h8, v); check("R12 count 15", v, 15);
    rd(4'h0, v); check("R3 below boundary", v, 0);
    tick(1);
    rd(4'h0, v); check("R3 same cycle as boundary", v, 0);
    @(negedge clk);
    rd(4'h0, v); check("R3 status set", v, 16'h0001);
    rd(4'h8, v); check("R12 count 16", v, 16);
    check("R2 sci timer masked", sci, 0);
    wr(4'h2, 16'h0001);
    check("R2 sci timer", sci, 1);
    wr(4'h0, 16'h0001);
    rd(4'h0, v); check("R4 timer cleared", v, 0);
    check("R2 sci drop", sci, 0);
    tick(15); @(negedge clk);
    rd(4'h0, v); check("R4 not before rearmed boundary", v, 0);
    tick(1); @(negedge clk);
    rd(4'h0, v); check("R4 rearmed boundary 32", v, 16'h0001);
    wr(4'h0, 16'h0001);
    wr(4'h2, 16'h0000);

    gpe_hp_sts = 1'b1; #1;
    check("R2 gpe only status", sci, 0);
    gpe_hp_en = 1'b1; #1;
    check("R2 gpe pair", sci, 1);
    gpe_hp_sts = 1'b0; gpe_hp_en = 1'b0;

    rtc_evt = 1'b1; glock_evt = 1'b1; @(negedge clk); rtc_evt = 1'b0; glock_evt = 1'b0;
    rd(4'h0, v); check("R4 alarm and lock set", v, 16'h0420);
    check("R2 alarm masked", sci, 0);
    wr(4'h2, 16'h0400);
    check("R2 alarm enabled", sci, 1);
    wr(4'h0, 16'h0400);
    rd(4'h0, v); check("R4 W1C one bit", v, 16'h0020);
    wr(4'h0, 16'h0020);

    wr(4'h2, 16'h0000);
    pwrbtn_evt = 1'b1; @(negedge clk); pwrbtn_evt = 1'b0;
    check("R10 button shutdown", shutdown_req, 1);
    rd(4'h0, v); check("R10 no status", v, 0);
    wr(4'h2, 16'h0100);
    pwrbtn_evt = 1'b1; @(negedge clk); pwrbtn_evt = 1'b0;
    check("R10 no shutdown", shutdown_req, 0);
    rd(4'h0, v); check("R10 button status", v, 16'h0100);
    check("R2 sci button", sci, 1);
    wr(4'h0, 16'h0100);
    wr(4'h2, 16'h0000);

    wr(4'h4, 16'h2000);
    check("R6 shutdown pulse", {shutdown_req, reset_req}, 2'b10);
    @(negedge clk);
    check("R6 pulse one cycle", shutdown_req, 0);
    rd(4'h4, v); check("R5 sleep bit reads 0", v, 0);

    check("R7 s3 low before", s3_active, 0);
    wr(4'h4, 16'h2400);
    check("R7 reset pulse", {shutdown_req, reset_req, s3_active}, 3'b011);
    rd(4'h0, v); check("R7 wake and button status", v, 16'h8100);
    rd(4'h4, v); check("R7 control readback", v, 16'h0400);
    @(negedge clk);
    check("R7 reset ends, s3 held", {reset_req, s3_active}, 2'b01);

    apm(8'hF1);
    rd(4'h4, v); check("R8 F1 sets", v, 16'h0401);
    check("R9 smi gated off", smi, 0);
    smi_cfg_en = 1'b1;
    apm(8'h55);
    rd(4'h4, v); check("R8 other byte ignored", v, 16'h0401);
    check("R9 smi pulse", smi, 1);
    apm(8'hF0);
    rd(4'h4, v); check("R8 F0 clears", v, 16'h0400);
    @(negedge clk);
    check("R9 smi one cycle", smi, 0);
    smi_cfg_en = 1'b0;

    apm_wr = 1'b1; apm_cmd = 8'hF1;
    wr(4'h4, 16'h0000);
    apm_wr = 1'b0;
    rd(4'h4, v); check("R11 APM sets over write", v, 16'h0001);
    apm_wr = 1'b1; apm_cmd = 8'hF0;
    wr(4'h4, 16'h0003);
    apm_wr = 1'b0;
    rd(4'h4, v); check("R11 APM clears over write", v, 16'h0002);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule